// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple request port and an asynchronous DRAM with multiplexed row/column addressing and a narrow data bus. Each accepted request carries a word address, a write flag and write data. The controller splits the address into a row half and a column half. It presents the row with a falling row strobe and the column with a falling column strobe, over the same address pins. Read data returns on a one-cycle valid pulse, in request order.

Once a row is open it stays open. Later requests to the same row become column-only page cycles, which saves the row activation and the precharge. The row is closed when a request targets another row, when the refresh side asks for the memory, or when the row has been held low close to its maximum allowed time. Writes use early-write timing. Write enable goes low before the column strobe falls and output enable stays high, so the memory never drives its data pins during a write.

All analogue timing limits are parameters in nanoseconds, together with the clock period. Each limit is rounded up to whole clock cycles inside the block.

Top module: `fpm_ctrl`

## Requirements
- R1: The upper half of the request address (bits [21:11] by default) is on the address pins when the row strobe falls. The lower half (bits [10:0]) is on the pins when the column strobe falls. The column strobe is low only while the row strobe is low. Accesses reach the memory in request order.
- R2: The row strobe stays high for at least the precharge count (4 cycles at defaults) before it falls. Successive row strobe falls are at least the random cycle count (11 cycles) apart. After reset, no request is accepted until a full precharge has elapsed.
- R3: Every row strobe low period lasts at least the minimum pulse count (6 cycles). It never exceeds the page-hold limit set by the open-time parameter.
- R4: Within one open row, successive column strobe falls are at least the page cycle count (4 cycles) apart. The column strobe is high for at least its precharge count (1 cycle) before each fall.
- R5: Read data is sampled only after the column access count (2 cycles) has elapsed since the column strobe fell and the row access count (6 cycles) since the row strobe fell. It is returned on rd_data with a one-cycle rd_valid pulse, in request order.
- R6: For a write, write enable (active low) is already low in the cycle before the column strobe falls. Output enable stays high and the write data is driven throughout the strobe-low period.
- R7: The row address stays on the pins for at least the row hold count (1 cycle) after the row strobe falls. The column address stays for at least the column hold count (1 cycle) after the column strobe falls.
- R8: Requests to the currently open row cause no new row strobe cycle. The row stays open while the port is idle.
- R9: A request to a different row raises the row strobe, waits out precharge, then opens the new row.
- R10: While refresh_req is high, the open row is closed and no request is accepted. refresh_gnt is high only with the row strobe high and precharge complete. After release, the next request opens its row again.
- R11: An open row that is left idle is closed by the block itself before the page-hold limit is reached.
- R12: Output enable is low only during reads and the data bus driver is on only during writes. The two are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_W | Word address, row in the upper half |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DQ_W | Read data |
| refresh_req | input | 1 | Refresh side asks for the memory |
| refresh_gnt | output | 1 | Memory idle, row closed and precharged |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ADDR_W | Multiplexed address pins |
| dram_dq_out | output | DQ_W | Data to memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | DQ_W | Data from memory |

## Verification
The embedded properties check, on every cycle, the pin-level rules that need no history beyond one cycle:
- the column strobe is only low inside a row strobe low period;
- output enable and the data driver are mutually exclusive;
- write enable is already low before a write strobe falls;
- the precharge count is met at each row strobe fall;
- the open-time counter stays below its limit;
- read data only follows an output-enabled cycle.

The bench's behavioural memory model and request scenarios show the rest:
- correct address split and data integrity;
- how many row activations a sequence of hits, misses, refresh hand-overs and idle time-outs costs;
- that reads only see valid data when the access counts are respected.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_PAGE
    } fpm_state_e;

    // round a time in ns up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_stopwatch.sv
`timescale 1ns/1ps
// Saturating cycle counter, cleared on a strobe edge.
module fpm_stopwatch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fpm_addr_split.sv
`timescale 1ns/1ps
// Splits a word address into row and column halves and compares the row.
module fpm_addr_split #(
    parameter int ADDR_W = 11
) (
    input  logic [2*ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0]   open_row,
    input  logic                open_vld,
    output logic [ADDR_W-1:0]   row,
    output logic [ADDR_W-1:0]   col,
    output logic                hit
);
    assign row = addr[2*ADDR_W-1:ADDR_W];
    assign col = addr[ADDR_W-1:0];
    assign hit = open_vld && (row == open_row);
endmodule

// File: rtl/fpm_ctrl.sv
`timescale 1ns/1ps
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ADDR_W    = 11,
    parameter int DQ_W      = 4,
    parameter int T_RC_NS   = 110,
    parameter int T_RP_NS   = 40,
    parameter int T_RAS_NS  = 60,
    parameter int T_RASP_NS = 200000,
    parameter int T_PC_NS   = 40,
    parameter int T_CP_NS   = 10,
    parameter int T_CAC_NS  = 15,
    parameter int T_RAC_NS  = 60,
    parameter int T_AA_NS   = 30,
    parameter int T_CAS_NS  = 15,
    parameter int T_RAH_NS  = 10,
    parameter int T_CAH_NS  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]     req_wdata,
    output logic                rd_valid,
    output logic [DQ_W-1:0]     rd_data,
    input  logic                refresh_req,
    output logic                refresh_gnt,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [ADDR_W-1:0]   dram_addr,
    output logic [DQ_W-1:0]     dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DQ_W-1:0]     dram_dq_in
);
    // timing limits in cycles
    localparam int RC_C   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int RP_C   = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int RAS_C  = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RASP_C = ns_to_cyc(T_RASP_NS, CLK_NS);
    localparam int PC_C   = ns_to_cyc(T_PC_NS, CLK_NS);
    localparam int CP_C   = ns_to_cyc(T_CP_NS, CLK_NS);
    localparam int CAC_C  = ns_to_cyc(T_CAC_NS, CLK_NS);
    localparam int RAC_C  = ns_to_cyc(T_RAC_NS, CLK_NS);
    localparam int AA_C   = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int CASW_C = ns_to_cyc(T_CAS_NS, CLK_NS);
    localparam int RAH_C  = ns_to_cyc(T_RAH_NS, CLK_NS);
    localparam int CAH_C  = ns_to_cyc(T_CAH_NS, CLK_NS);

    localparam int RASLOW_C = imax(RAS_C, RC_C - RP_C);
    localparam int CHOLD_C  = imax(imax(CAC_C, CASW_C), imax(CAH_C, AA_C - 1));
    localparam int GUARD_C  = PC_C + CP_C + CHOLD_C + RAC_C + 4;
    localparam int LAST_C   = RASP_C - GUARD_C;
    localparam int CW       = $clog2(RASP_C + 2) + 1;

    localparam logic [CW-1:0] RP_K     = CW'(RP_C);
    localparam logic [CW-1:0] RASP_K   = CW'(RASP_C);
    localparam logic [CW-1:0] PC_K     = CW'(PC_C);
    localparam logic [CW-1:0] CP_K     = CW'(CP_C);
    localparam logic [CW-1:0] RAC_K    = CW'(RAC_C);
    localparam logic [CW-1:0] RAH_K    = CW'(RAH_C);
    localparam logic [CW-1:0] RASLOW_K = CW'(RASLOW_C);
    localparam logic [CW-1:0] CHOLD_K  = CW'(CHOLD_C);
    localparam logic [CW-1:0] LAST_K   = CW'(LAST_C);

    typedef struct packed {
        fpm_state_e        st;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] pin_addr;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] open_row;
        logic              open_vld;
        logic              is_wr;
        logic [DQ_W-1:0]   wdata;
        logic              rd_vld;
        logic [DQ_W-1:0]   rd_data;
    } ctl_t;

    localparam ctl_t RST_V = '{st: ST_IDLE, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                               oe_n: 1'b1, dq_oe: 1'b0, pin_addr: '0, col: '0,
                               open_row: '0, open_vld: 1'b0, is_wr: 1'b0,
                               wdata: '0, rd_vld: 1'b0, rd_data: '0};

    ctl_t q, d;

    logic [CW-1:0]     ras_cnt, pre_cnt, casf_cnt, casr_cnt;
    logic [ADDR_W-1:0] req_row, req_col;
    logic              req_hit, pre_ok, late;

    // strobe-edge stopwatches
    fpm_stopwatch #(.W(CW)) u_ras_low  (.clk(clk), .rst_n(rst_n),
        .clr(q.ras_n && !d.ras_n), .cnt(ras_cnt));
    fpm_stopwatch #(.W(CW)) u_ras_high (.clk(clk), .rst_n(rst_n),
        .clr(!q.ras_n && d.ras_n), .cnt(pre_cnt));
    fpm_stopwatch #(.W(CW)) u_cas_low  (.clk(clk), .rst_n(rst_n),
        .clr(q.cas_n && !d.cas_n), .cnt(casf_cnt));
    fpm_stopwatch #(.W(CW)) u_cas_high (.clk(clk), .rst_n(rst_n),
        .clr(!q.cas_n && d.cas_n), .cnt(casr_cnt));

    fpm_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr(req_addr), .open_row(q.open_row), .open_vld(q.open_vld),
        .row(req_row), .col(req_col), .hit(req_hit)
    );

    assign pre_ok = pre_cnt >= RP_K;
    assign late   = ras_cnt >= LAST_K;

    always_comb begin
        d         = q;
        d.rd_vld  = 1'b0;
        req_ready = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                req_ready = pre_ok && !refresh_req;
                if (req_ready && req_valid) begin
                    d.st       = ST_ROW;
                    d.ras_n    = 1'b0;
                    d.pin_addr = req_row;
                    d.open_row = req_row;
                    d.open_vld = 1'b1;
                    d.col      = req_col;
                    d.is_wr    = req_write;
                    d.wdata    = req_wdata;
                end
            end
            ST_ROW: begin
                if (ras_cnt >= RAH_K) begin
                    d.st       = ST_COL;
                    d.pin_addr = q.col;
                    d.we_n     = !q.is_wr;
                    d.oe_n     = q.is_wr;
                    d.dq_oe    = q.is_wr;
                end
            end
            ST_COL: begin
                if (casf_cnt >= PC_K && casr_cnt >= CP_K) begin
                    d.st    = ST_CAS;
                    d.cas_n = 1'b0;
                end
            end
            ST_CAS: begin
                if (casf_cnt >= CHOLD_K && (q.is_wr || ras_cnt >= RAC_K)) begin
                    d.st    = ST_PAGE;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    if (!q.is_wr) begin
                        d.rd_vld  = 1'b1;
                        d.rd_data = dram_dq_in;
                    end
                end
            end
            ST_PAGE: begin
                if (refresh_req || late || (req_valid && !req_hit)) begin
                    if (ras_cnt >= RASLOW_K) begin
                        d.st       = ST_IDLE;
                        d.ras_n    = 1'b1;
                        d.open_vld = 1'b0;
                    end
                end else begin
                    req_ready = req_hit;
                    if (req_valid && req_hit) begin
                        d.st       = ST_COL;
                        d.col      = req_col;
                        d.pin_addr = req_col;
                        d.is_wr    = req_write;
                        d.wdata    = req_wdata;
                        d.we_n     = !req_write;
                        d.oe_n     = req_write;
                        d.dq_oe    = req_write;
                    end
                end
            end
            default: d = RST_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_V;
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rd_vld;
    assign rd_data     = q.rd_data;
    assign refresh_gnt = (q.st == ST_IDLE) && pre_ok && refresh_req;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.pin_addr;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.dq_oe;

    AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R1
    AST_PRECHARGE_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(pre_cnt) >= RP_K); // R2
    AST_OPEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> ras_cnt < RASP_K); // R3
    AST_RD_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_oe_n)); // R5
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) && !dram_we_n |-> $past(!dram_we_n)); // R6
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n); // R6
    AST_OE_DRV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_oe_n && dram_dq_oe)); // R12

endmodule

// File: tb/fpm_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_ctrl_bench;
    localparam int RC_C = 11, RP_C = 4, RAS_C = 6, RASP_C = 150;
    localparam int PC_C = 4, CP_C = 1, CAC_C = 2, RAC_C = 6, RAH_C = 1, CAH_C = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0, dram_dq_in = '0;
    logic        req_ready, rd_valid, refresh_gnt;
    logic [3:0]  rd_data, dram_dq_out;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [10:0] dram_addr;

    always #5 clk = ~clk;

    fpm_ctrl #(.T_RASP_NS(1500)) u_fpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
        .refresh_gnt(refresh_gnt), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0;
    logic [3:0] model_mem [int];
    logic [3:0] shadow [int];
    int iss_addr[$]; bit iss_wr[$]; int iss_data[$]; int exp_rd[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] dflt(input int a);
        return a[3:0] ^ a[14:11];
    endfunction

    function automatic int mk(input int r, input int c);
        return r * 2048 + c;
    endfunction

    // ---- memory model and protocol monitor, sampled mid-cycle ----
    int rl, rh, cl, ch, cgap, since_fall, ras_falls, wd;
    bit p_ras, p_cas, p_we, seen_fall, first_cas;
    int row, col, cur_a, ea;
    logic [3:0] word;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 1; p_cas = 1; p_we = 1; rl = 0; rh = 0; cl = 0; ch = 0;
            cgap = 0; since_fall = 0; seen_fall = 0; first_cas = 1; row = 0; col = 0;
            ras_falls = 0;
            dram_dq_in = '0;
        end else begin
            chk(!(!dram_oe_n && dram_dq_oe), "R12 oe/driver exclusive", 1, 0);
            if (!dram_ras_n) begin
                if (p_ras) begin
                    chk(rh >= RP_C, "R2 precharge", rh, RP_C);
                    if (seen_fall) chk(since_fall >= RC_C, "R2 cycle time", since_fall, RC_C);
                    seen_fall = 1; since_fall = 0; ras_falls++;
                    row = int'(dram_addr); rl = 1; first_cas = 1;
                end else rl++;
                if (rl == RAH_C + 1) chk(int'(dram_addr) == row, "R7 row hold", int'(dram_addr), row);
            end else begin
                if (!p_ras) begin
                    chk(rl >= RAS_C, "R3 ras min", rl, RAS_C);
                    chk(rl <= RASP_C, "R3 ras max", rl, RASP_C);
                    rh = 1;
                end else rh++;
            end
            since_fall++;
            if (!dram_cas_n) begin
                if (p_cas) begin
                    chk(!dram_ras_n, "R1 cas inside ras", int'(dram_ras_n), 0);
                    if (!first_cas) chk(cgap >= PC_C, "R4 page cycle", cgap, PC_C);
                    chk(ch >= CP_C, "R4 cas precharge", ch, CP_C);
                    first_cas = 0; cgap = 0; cl = 1; col = int'(dram_addr);
                    cur_a = mk(row, col);
                    if (iss_addr.size() == 0) begin
                        chk(0, "R1 unexpected access", cur_a, -1);
                    end else begin
                        ea = iss_addr.pop_front();
                        chk(cur_a == ea, "R1 address", cur_a, ea);
                        if (iss_wr.pop_front()) begin
                            chk(!dram_we_n, "R6 write flag", int'(dram_we_n), 0);
                            chk(!p_we, "R6 early write", int'(p_we), 0);
                            chk(dram_oe_n && dram_dq_oe, "R6 oe high, driver on",
                                int'({dram_oe_n, dram_dq_oe}), 3);
                            ea = iss_data.pop_front();
                            chk(int'(dram_dq_out) == ea, "R6 write data", int'(dram_dq_out), ea);
                            if (!dram_we_n) model_mem[cur_a] = dram_dq_out;
                        end else begin
                            void'(iss_data.pop_front());
                            chk(!dram_oe_n && !dram_dq_oe && dram_we_n, "R12 read controls",
                                int'({dram_oe_n, dram_dq_oe, dram_we_n}), 1);
                        end
                    end
                end else cl++;
                if (cl == CAH_C + 1) chk(int'(dram_addr) == col, "R7 column hold", int'(dram_addr), col);
            end else begin
                if (!p_cas) ch = 1; else ch++;
            end
            cgap++;
            if (rd_valid) begin
                if (exp_rd.size() == 0) chk(0, "R5 unexpected read", int'(rd_data), -1);
                else begin
                    ea = exp_rd.pop_front();
                    chk(int'(rd_data) == ea, "R5 read data", int'(rd_data), ea);
                end
            end
            word = model_mem.exists(cur_a) ? model_mem[cur_a] : dflt(cur_a);
            if (!dram_cas_n && !dram_oe_n && cl > CAC_C && rl > RAC_C) dram_dq_in = word;
            else dram_dq_in = ~word;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
        end
    end

    // watchdog
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input int a, input bit wr, input logic [3:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a[21:0]; req_write = wr; req_wdata = dat;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        iss_addr.push_back(a); iss_wr.push_back(wr); iss_data.push_back(int'(dat));
        if (wr) shadow[a] = dat;
        else exp_rd.push_back(int'(shadow.exists(a) ? shadow[a] : dflt(a)));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (20) @(negedge clk);
    endtask

    int f0;
    bit got;
    bit [31:0] lcg;
    int rsel [3] = '{3, 4, 2047};

    initial begin
        wd = 0;
        repeat (4) @(negedge clk);
        // reset state
        chk(dram_ras_n && dram_cas_n, "R1 strobes idle in reset", int'({dram_ras_n, dram_cas_n}), 3);
        chk(dram_oe_n && dram_we_n && !dram_dq_oe, "R12 controls idle in reset",
            int'({dram_oe_n, dram_we_n, dram_dq_oe}), 6);
        chk(!rd_valid, "R5 no read pulse in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!req_ready, "R2 not ready before precharge", int'(req_ready), 0);

        // page hits
        f0 = ras_falls;
        send(mk(5, 1), 1, 4'h3);
        send(mk(5, 2), 1, 4'hC);
        send(mk(5, 1), 0, 4'h0);
        send(mk(5, 2), 0, 4'h0);
        send(mk(5, 7), 0, 4'h0);
        drain();
        chk(ras_falls - f0 == 1, "R8 one activation for hits", ras_falls - f0, 1);
        chk(!dram_ras_n, "R8 row kept open while idle", int'(dram_ras_n), 0);

        // row misses
        f0 = ras_falls;
        send(mk(9, 3), 1, 4'hA);
        send(mk(5, 1), 0, 4'h0);
        send(mk(9, 3), 0, 4'h0);
        drain();
        chk(ras_falls - f0 == 3, "R9 activation per miss", ras_falls - f0, 3);

        // refresh hand-over
        @(negedge clk);
        refresh_req = 1'b1;
        got = 0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk); #1;
            if (refresh_gnt) got = 1;
        end
        chk(got, "R10 grant given", int'(got), 1);
        chk(dram_ras_n, "R10 row closed at grant", int'(dram_ras_n), 1);
        chk(rh >= RP_C, "R10 precharged at grant", rh, RP_C);
        chk(!req_ready, "R10 no accept during refresh", int'(req_ready), 0);
        repeat (5) @(negedge clk);
        chk(dram_ras_n && refresh_gnt, "R10 memory left idle", int'({dram_ras_n, refresh_gnt}), 3);
        refresh_req = 1'b0;
        f0 = ras_falls;
        send(mk(9, 3), 0, 4'h0);
        drain();
        chk(ras_falls - f0 == 1, "R10 row reopened", ras_falls - f0, 1);

        // open time limit
        send(mk(2, 2), 1, 4'h5);
        repeat (200) @(negedge clk);
        chk(dram_ras_n, "R11 idle row closed", int'(dram_ras_n), 1);
        f0 = ras_falls;
        send(mk(2, 2), 0, 4'h0);
        drain();
        chk(ras_falls - f0 == 1, "R11 reopen after limit", ras_falls - f0, 1);

        // address extremes
        send(mk(0, 0), 1, 4'h9);
        send(mk(2047, 2047), 1, 4'h6);
        send(mk(0, 0), 0, 4'h0);
        send(mk(2047, 2047), 0, 4'h0);

        // mixed traffic
        lcg = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            send(mk(rsel[lcg[30:29] % 3], int'(lcg[10:0])), lcg[20], lcg[24:21]);
        end
        drain();
        chk(exp_rd.size() == 0, "R5 all reads returned", exp_rd.size(), 0);
        chk(iss_addr.size() == 0, "R1 all accesses issued", iss_addr.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule